// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sleep and Wakeup

This block turns an asynchronous serial line into received characters. The line is sampled on a 16x tick supplied from outside. Each bit is decided by a three-sample majority vote near the middle of the bit. A start bit that does not hold low at its middle is discarded as noise. The character format is chosen by three configuration inputs: the character length, whether parity is used, and the parity sense. A character holds 8 or 9 bits, and when parity is enabled the top bit of the character is the parity bit.

The receiver also detects idle lines. An idle character is one full frame time of continuous 1s. A configuration input selects when the count of 1s begins. It can begin right after the start bit, so trailing 1s in the data count toward idle. It can instead begin after the stop bit. The idle flag is raised at most once per idle stretch.

A sleep state, entered by a one-cycle request, hides received characters and idle events until a wakeup condition occurs. The wakeup is either a character whose top bit is 1 (an address mark) or an idle line. Interrupt requests are the receive-full and idle flags, each gated by its own enable.

Top module: `rxw_receiver`

## Requirements
- R1: A frame is one low start bit, 8 + `cfg_nine` character bits sent least significant first, and one high stop bit. `rx_data` holds the character right-aligned, and bit 8 reads 0 when `cfg_nine` is 0.
- R2: With `cfg_par_en` = 1, `rx_perr` is set with the character when the count of 1s across all its bits (parity bit at the top position included) is odd for `cfg_par_odd` = 0, or even for `cfg_par_odd` = 1. With `cfg_par_en` = 0, `rx_perr` stays 0.
- R3: A bit value is the majority of three 16x samples around mid-bit. A start bit that reads high at mid-bit is dropped, and no character results.
- R4: A delivered character sets `rx_full` and loads `rx_data`. Both hold until a `flag_clr` pulse, which clears `rx_full`, `rx_idle` and `rx_perr`. A delivery in the same cycle as the pulse takes priority.
- R5: With `cfg_idle_after_stop` = 1, counting of 1s toward idle starts only after the stop bit. `rx_idle` is set after (10 + `cfg_nine`) bit times of 1s.
- R6: With `cfg_idle_after_stop` = 0, counting starts after the start bit. High data bits just before the stop bit count toward the total, so idle can be declared early.
- R7: `rx_idle` is set at most once per idle stretch. It is re-armed only by a received character, and it is never armed straight out of reset.
- R8: While `asleep` = 1, neither `rx_full` nor `rx_idle` is set. A `sleep_set` pulse enters the sleep state.
- R9: With `cfg_wake_addr` = 1, a character whose top bit is 1 clears `asleep` and is delivered as a received character. Idle lines do not wake the receiver.
- R10: With `cfg_wake_addr` = 0, an idle detection clears `asleep` and is not reported on `rx_idle`. Characters do not wake the receiver.
- R11: `irq_full` = `rx_full` AND `irq_full_en`, and `irq_idle` = `rx_idle` AND `irq_idle_en`.
- R12: After reset all flags, interrupt requests and `asleep` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_nine | input | 1 | 1 selects a 9-bit character, 0 selects 8 bits |
| cfg_par_en | input | 1 | Top character bit is parity when 1 |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_wake_addr | input | 1 | 1 wakes on an address mark, 0 wakes on an idle line |
| cfg_idle_after_stop | input | 1 | 1 starts idle counting after the stop bit, 0 after the start bit |
| sleep_set | input | 1 | One-cycle pulse that enters the sleep state |
| flag_clr | input | 1 | One-cycle pulse that clears the full, idle and parity flags |
| irq_full_en | input | 1 | Enable for the receive-full request |
| irq_idle_en | input | 1 | Enable for the idle request |
| rx_data | output | 9 | Last delivered character |
| rx_full | output | 1 | Character waiting |
| rx_idle | output | 1 | Idle line seen |
| rx_perr | output | 1 | Parity error on the waiting character |
| asleep | output | 1 | Sleep state |
| irq_full | output | 1 | Gated receive-full request |
| irq_idle | output | 1 | Gated idle request |

## Verification
The assertions assume that `flag_clr` and `sleep_set` are single-cycle pulses. They also assume the configuration inputs change only while the line idles between frames, because a mid-frame change of format or wake mode alters the meaning of the character being assembled. The stimulus changes configuration only after each frame's stop bit has been sent. It holds `rxd` at whole bit times of 64 clocks, which is 16 ticks of 4 clocks each. The one exception is the short glitches meant to exercise the vote and the start-bit rejection.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_STOP  = 2'd3
   } rx_state_t;

   typedef struct packed {
      logic nine;
      logic par_en;
      logic par_odd;
   } rx_fmt_t;

   localparam int unsigned CHAR_W = 9;

   function automatic logic [3:0] char_bits(input rx_fmt_t f);
      return f.nine ? 4'd9 : 4'd8;
   endfunction

   function automatic logic [3:0] frame_bits(input rx_fmt_t f);
      return f.nine ? 4'd11 : 4'd10;
   endfunction

endpackage

// File: rtl/rxw_sampler.sv
module rxw_sampler #(
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          MAJORITY_VOTE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic rxd,
   output logic line,
   output logic vote
);

   logic [2:0] hist_q;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= 1'b1;
            else        s_q <= rxd;
         end
         assign line = s_q;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '1;
            else        s_q <= {s_q[SYNC_STAGES-2:0], rxd};
         end
         assign line = s_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hist_q <= 3'b111;
      else if (tick) hist_q <= {hist_q[1:0], line};
   end

   generate
      if (MAJORITY_VOTE) begin : g_vote3
         assign vote = (hist_q[0] & hist_q[1]) | (hist_q[1] & hist_q[2]) |
                       (hist_q[0] & hist_q[2]);
      end else begin : g_vote1
         logic unused_hist;
         assign unused_hist = ^hist_q[2:1];
         assign vote = hist_q[0];
      end
   endgenerate

endmodule

// File: rtl/rxw_framer.sv
module rxw_framer
   import rxw_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                line,
   input  logic                vote,
   input  rx_fmt_t             fmt,
   output logic                done,
   output logic [CHAR_W-1:0]   char_o,
   output logic                msb_o,
   output logic                perr_o,
   output logic                in_idle,
   output logic                in_start
);

   localparam int unsigned PH_W    = $clog2(OVERSAMPLE);
   localparam int unsigned DEC_PH  = OVERSAMPLE / 2 + 2;
   localparam int unsigned LAST_PH = OVERSAMPLE - 1;

   rx_state_t            st_q;
   logic [PH_W-1:0]      ph_q;
   logic [3:0]           bit_q;
   logic [CHAR_W-1:0]    sh_q;
   logic                 done_q;
   logic                 at_dec, at_last;

   assign at_dec  = (ph_q == PH_W'(DEC_PH));
   assign at_last = (ph_q == PH_W'(LAST_PH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ph_q   <= '0;
         bit_q  <= '0;
         sh_q   <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (tick) begin
            ph_q <= ph_q + 1'b1;
            case (st_q)
               ST_IDLE: begin
                  ph_q <= PH_W'(1);
                  if (!line) begin
                     st_q <= ST_START;
                     sh_q <= '0;
                  end
               end
               ST_START: begin
                  if (at_dec && vote) begin
                     st_q <= ST_IDLE;
                  end else if (at_last) begin
                     st_q  <= ST_DATA;
                     ph_q  <= '0;
                     bit_q <= '0;
                  end
               end
               ST_DATA: begin
                  if (at_dec) sh_q[bit_q] <= vote;
                  if (at_last) begin
                     ph_q <= '0;
                     if (bit_q == char_bits(fmt) - 4'd1) st_q <= ST_STOP;
                     else                                bit_q <= bit_q + 4'd1;
                  end
               end
               default: begin
                  if (at_dec) begin
                     st_q   <= ST_IDLE;
                     done_q <= 1'b1;
                  end
               end
            endcase
         end
      end
   end

   assign done     = done_q;
   assign char_o   = sh_q;
   assign msb_o    = fmt.nine ? sh_q[8] : sh_q[7];
   assign perr_o   = fmt.par_en & ((^sh_q) != fmt.par_odd);
   assign in_idle  = (st_q == ST_IDLE);
   assign in_start = (st_q == ST_START);

endmodule

// File: rtl/rxw_idle_det.sv
module rxw_idle_det #(
   parameter int unsigned OVERSAMPLE = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic line,
   input  logic nine,
   input  logic after_stop,
   input  logic in_idle,
   input  logic in_start,
   input  logic char_done,
   output logic idle_evt
);

   localparam int unsigned CW = $clog2(11 * OVERSAMPLE + 1);
   localparam logic [CW-1:0] THR_SHORT = CW'(10 * OVERSAMPLE);
   localparam logic [CW-1:0] THR_LONG  = CW'(11 * OVERSAMPLE);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] thr;
   logic          armed_q, evt_q, cnt_en;

   assign thr    = nine ? THR_LONG : THR_SHORT;
   assign cnt_en = after_stop ? in_idle : !in_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
         evt_q   <= 1'b0;
      end else begin
         evt_q <= 1'b0;
         if (tick) begin
            if (!cnt_en || !line) begin
               cnt_q <= '0;
            end else if (cnt_q < thr) begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == thr - 1'b1 && armed_q) begin
                  evt_q   <= 1'b1;
                  armed_q <= 1'b0;
               end
            end
         end
         if (char_done) armed_q <= 1'b1;
      end
   end

   assign idle_evt = evt_q;

endmodule

// File: rtl/rxw_receiver.sv
module rxw_receiver
   import rxw_pkg::*;
#(
   parameter int unsigned OVERSAMPLE    = 16,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          MAJORITY_VOTE = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick16,
   input  logic        rxd,
   input  logic        cfg_nine,
   input  logic        cfg_par_en,
   input  logic        cfg_par_odd,
   input  logic        cfg_wake_addr,
   input  logic        cfg_idle_after_stop,
   input  logic        sleep_set,
   input  logic        flag_clr,
   input  logic        irq_full_en,
   input  logic        irq_idle_en,
   output logic [8:0]  rx_data,
   output logic        rx_full,
   output logic        rx_idle,
   output logic        rx_perr,
   output logic        asleep,
   output logic        irq_full,
   output logic        irq_idle
);

   initial begin
      assert (OVERSAMPLE >= 8 && OVERSAMPLE <= 64)
         else $fatal(1, "OVERSAMPLE must lie in 8..64");
      assert (SYNC_STAGES >= 1)
         else $fatal(1, "SYNC_STAGES must be at least 1");
   end

   rx_fmt_t             fmt;
   logic                line, vote;
   logic                done, msb, perr_c, in_idle, in_start, idle_evt;
   logic [CHAR_W-1:0]   chr;
   logic                deliver, wake_idle;
   logic                asleep_q, full_q, idle_q, perr_q;
   logic [CHAR_W-1:0]   data_q;

   assign fmt = '{nine: cfg_nine, par_en: cfg_par_en, par_odd: cfg_par_odd};

   rxw_sampler #(
      .SYNC_STAGES   (SYNC_STAGES),
      .MAJORITY_VOTE (MAJORITY_VOTE)
   ) u_sampler (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick16),
      .rxd   (rxd),
      .line  (line),
      .vote  (vote)
   );

   rxw_framer #(
      .OVERSAMPLE (OVERSAMPLE)
   ) u_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick16),
      .line     (line),
      .vote     (vote),
      .fmt      (fmt),
      .done     (done),
      .char_o   (chr),
      .msb_o    (msb),
      .perr_o   (perr_c),
      .in_idle  (in_idle),
      .in_start (in_start)
   );

   rxw_idle_det #(
      .OVERSAMPLE (OVERSAMPLE)
   ) u_idle (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick16),
      .line       (line),
      .nine       (cfg_nine),
      .after_stop (cfg_idle_after_stop),
      .in_idle    (in_idle),
      .in_start   (in_start),
      .char_done  (done),
      .idle_evt   (idle_evt)
   );

   assign deliver   = done & (!asleep_q | (cfg_wake_addr & msb));
   assign wake_idle = idle_evt & asleep_q & !cfg_wake_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         asleep_q <= 1'b0;
         full_q   <= 1'b0;
         idle_q   <= 1'b0;
         perr_q   <= 1'b0;
         data_q   <= '0;
      end else begin
         if (deliver || wake_idle) asleep_q <= 1'b0;
         if (sleep_set)            asleep_q <= 1'b1;
         if (flag_clr) begin
            full_q <= 1'b0;
            idle_q <= 1'b0;
            perr_q <= 1'b0;
         end
         if (deliver) begin
            full_q <= 1'b1;
            data_q <= chr;
            perr_q <= perr_c;
         end
         if (idle_evt && !asleep_q) idle_q <= 1'b1;
      end
   end

   assign rx_data  = data_q;
   assign rx_full  = full_q;
   assign rx_idle  = idle_q;
   assign rx_perr  = perr_q;
   assign asleep   = asleep_q;
   assign irq_full = full_q & irq_full_en;
   assign irq_idle = idle_q & irq_idle_en;

endmodule

// File: rtl/rxw_receiver_chk.sv
module rxw_receiver_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       flag_clr,
   input logic       irq_full_en,
   input logic       irq_idle_en,
   input logic       cfg_wake_addr,
   input logic [8:0] rx_data,
   input logic       rx_full,
   input logic       rx_idle,
   input logic       rx_perr,
   input logic       asleep,
   input logic       irq_full,
   input logic       irq_idle
);

   assert_full_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full && !flag_clr |=> rx_full);

   assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_data) |-> rx_full);

   assert_perr_with_char_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_perr |-> rx_full);

   assert_full_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_full_en |-> !irq_full);

   assert_idle_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_idle_en |-> !irq_idle);

   assert_quiet_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> !asleep);

   assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_idle) |-> !$past(asleep));

   assert_mark_delivered_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(asleep) && $past(cfg_wake_addr) |-> rx_full);

endmodule

bind rxw_receiver rxw_receiver_chk u_chk (.*);

// File: tb/rxw_receiver_bench.sv
`timescale 1ns/1ps
module rxw_receiver_bench;

   localparam int BIT_CLK = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       rxd = 1'b1;
   logic       cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
   logic       cfg_wake_addr = 1'b0, cfg_idle_after_stop = 1'b0;
   logic       sleep_set = 1'b0, flag_clr = 1'b0;
   logic       irq_full_en = 1'b0, irq_idle_en = 1'b0;
   logic [8:0] rx_data;
   logic       rx_full, rx_idle, rx_perr, asleep, irq_full, irq_idle;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic [1:0] tdiv = 2'd0;

   always #2 clk = ~clk;

   always @(posedge clk) begin
      tdiv   <= tdiv + 2'd1;
      tick16 <= (tdiv == 2'd3);
   end

   rxw_receiver u_rxw_receiver (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bit_time(input logic v);
      rxd = v;
      repeat (BIT_CLK) @(negedge clk);
   endtask

   task automatic idle_bits(input int n);
      rxd = 1'b1;
      repeat (n * BIT_CLK) @(negedge clk);
   endtask

   task automatic send_char(input logic [8:0] ch, input logic nine);
      bit_time(1'b0);
      for (int i = 0; i < 8 + int'(nine); i++) bit_time(ch[i]);
      bit_time(1'b1);
   endtask

   task automatic pulse_clr();
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
   endtask

   task automatic pulse_sleep();
      sleep_set = 1'b1;
      @(negedge clk);
      sleep_set = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual hung expected done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [8:0] ch;
      logic [8:0] mask;
      logic       exp_perr;
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12: reset state
      check("R12 full", rx_full, 0);
      check("R12 idle", rx_idle, 0);
      check("R12 perr", rx_perr, 0);
      check("R12 asleep", asleep, 0);
      check("R12 irqs", {irq_full, irq_idle}, 0);
      idle_bits(12);
      check("R7 no idle out of reset", rx_idle, 0);

      // R1, R2, R4: sweep of every format
      for (int f = 0; f < 8; f++) begin
         cfg_nine    = f[2];
         cfg_par_en  = f[1];
         cfg_par_odd = f[0];
         mask = cfg_nine ? 9'h1FF : 9'h0FF;
         for (int k = 0; k < 12; k++) begin
            ch = 9'((k * 37 + 5 + f * k * 53 + f * 11)) & mask;
            exp_perr = cfg_par_en ? ((^ch) != cfg_par_odd) : 1'b0;
            pulse_clr();
            send_char(ch, cfg_nine);
            check("R4 full set", rx_full, 1);
            check("R1 data", rx_data, ch);
            check("R2 parity", rx_perr, exp_perr);
         end
      end
      pulse_clr();
      check("R4 clear", {rx_full, rx_perr}, 0);
      check("R4 data held", rx_data, ch);
      cfg_nine = 1'b0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

      // R3: short start glitch, then majority vote inside a bit
      idle_bits(12);
      pulse_clr();
      rxd = 1'b0;
      repeat (16) @(negedge clk);
      idle_bits(12);
      check("R3 glitch rejected", rx_full, 0);
      bit_time(1'b0);
      for (int i = 0; i < 3; i++) bit_time(1'b0);
      rxd = 1'b0; repeat (32) @(negedge clk);
      rxd = 1'b1; repeat (4)  @(negedge clk);
      rxd = 1'b0; repeat (28) @(negedge clk);
      for (int i = 4; i < 8; i++) bit_time(1'b0);
      bit_time(1'b1);
      check("R3 vote full", rx_full, 1);
      check("R3 vote data", rx_data, 0);

      // R5: count after stop
      cfg_idle_after_stop = 1'b1;
      idle_bits(12);
      pulse_clr();
      send_char(9'h0FF, 1'b0);
      pulse_clr();
      idle_bits(8);
      check("R5 not yet idle", rx_idle, 0);
      idle_bits(3);
      check("R5 idle", rx_idle, 1);
      // R11 idle gating
      check("R11 idle irq off", irq_idle, 0);
      irq_idle_en = 1'b1;
      #0; @(negedge clk);
      check("R11 idle irq on", irq_idle, 1);
      irq_idle_en = 1'b0;
      // R7: once per stretch, re-armed by a character
      pulse_clr();
      idle_bits(12);
      check("R7 once only", rx_idle, 0);
      send_char(9'h000, 1'b0);
      idle_bits(11);
      check("R7 rearmed", rx_idle, 1);

      // R6: count after start bit, early idle
      cfg_idle_after_stop = 1'b0;
      idle_bits(12);
      pulse_clr();
      send_char(9'h0FF, 1'b0);
      check("R6 not at stop end", rx_idle, 0);
      idle_bits(2);
      check("R6 early idle", rx_idle, 1);
      idle_bits(12);
      pulse_clr();
      send_char(9'h000, 1'b0);
      idle_bits(2);
      check("R6 zeros no early idle", rx_idle, 0);
      idle_bits(10);
      pulse_clr();

      // R8, R9: address-mark wake
      cfg_wake_addr = 1'b1;
      pulse_sleep();
      check("R8 asleep", asleep, 1);
      send_char(9'h012, 1'b0);
      check("R8 char hidden", rx_full, 0);
      idle_bits(12);
      check("R8 idle hidden", rx_idle, 0);
      check("R9 idle no wake", asleep, 1);
      send_char(9'h085, 1'b0);
      check("R9 woke", asleep, 0);
      check("R9 mark delivered", rx_full, 1);
      check("R9 mark data", rx_data, 9'h085);
      // R11 full gating
      check("R11 full irq off", irq_full, 0);
      irq_full_en = 1'b1;
      @(negedge clk);
      check("R11 full irq on", irq_full, 1);
      irq_full_en = 1'b0;

      // R10: idle-line wake
      idle_bits(12);
      pulse_clr();
      cfg_wake_addr = 1'b0;
      pulse_sleep();
      send_char(9'h0B3, 1'b0);
      check("R10 char no wake", asleep, 1);
      check("R10 char hidden", rx_full, 0);
      idle_bits(12);
      check("R10 idle woke", asleep, 0);
      check("R10 wake not reported", rx_idle, 0);
      check("R10 full clear", rx_full, 0);

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule